// File: doc/BRIEF.md
# Burst Master Read Sequencer

This block runs the initiator side of a read of a programmed number of 64-bit quad words on a simplified multiplexed address/data bus. The application gives a start address and an 18-bit word count with a one-cycle `start` pulse. The sequencer then drives an address phase and a data phase, and passes every quad word it receives straight into a downstream FIFO through a valid/ready handshake.

When the target ends a transaction early with a retry or a disconnect, the sequencer starts a new transaction on its own. The new transaction begins at the first quad word not yet received. Whether the read is a single transfer or a burst depends only on the start address: there is no last-cycle input. An operation ends on completion, target abort, no target response (master abort), an application stop request or bus reset. The end is reported by a one-cycle `done` pulse with an end code. Byte enables come from the application and go onto the bus during data phases only. They are never stored with the returned data.

Top module: `mrd_burst_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `busy`, `done`, `bus_addr_valid`, `bus_data_phase`, `bus_irdy` and `fifo_valid` are all 0.
- R2: A start with a count of 0 issues no address phase and gives `done` in the next cycle with `end_code` 0 (complete), whatever the address.
- R3: A start with a non-zero count, address bit 2 clear and address bits 5:3 not all zero is rejected. No address phase is issued, and `done` follows in the next cycle with `end_code` 5 (alignment error).
- R4: A start with a non-zero count and address bit 2 set moves exactly one quad word, whatever the count (up to 2^18−1). Its address phase shows `bus_burst` = 0.
- R5: The cycle after an accepted start is a single address phase. In it `bus_addr` equals the start address and `bus_burst` is 1 exactly when more than one quad word remains. Data-phase cycles follow it.
- R6: A read of N quad words from a 64-byte-aligned address delivers exactly N words, in order. Each word is passed through unchanged as `fifo_data` in the cycle it is taken. `done` with `end_code` 0 follows the cycle of the last word.
- R7: A retry (no data taken in that cycle) or a disconnect (data taken if the target is ready) before the last word leads, in the next cycle, to a new address phase at start address + 8 × (words received).
- R8: A target abort in a data phase takes no data in that cycle. `done` with `end_code` 2 follows.
- R9: If the target gives no response (ready, retry, disconnect or abort) in the 5 data-phase cycles after an address phase, `done` with `end_code` 1 follows the fifth cycle. A response in one of those cycles cancels the timeout.
- R10: `stop_req` in an address or data phase ends the operation with `end_code` 3. A word taken in that same cycle is still delivered, and completion takes priority when that word is the last one.
- R11: `bus_reset` during an operation takes no data and ends it with `end_code` 4. It has the highest priority of all end causes.
- R12: During data phases `bus_irdy` follows `fifo_ready`. A word is taken only when `fifo_ready` and target ready are both high. `fifo_valid` is never high while `fifo_ready` is low.
- R13: `bus_be` equals `rd_be` during data-phase cycles and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a read (taken when idle) |
| start_addr | input | ADDR_W | Byte address of the first quad word |
| start_count | input | CNT_W | Number of quad words to read |
| stop_req | input | 1 | Application request to end the operation |
| bus_reset | input | 1 | Bus reset, ends any operation at once |
| rd_be | input | DATA_W/8 | Byte enables from the application |
| bus_addr_valid | output | 1 | Address phase strobe |
| bus_addr | output | ADDR_W | Address driven in the address phase |
| bus_burst | output | 1 | Address phase announces more than one word |
| bus_data_phase | output | 1 | Initiator is in a data phase |
| bus_irdy | output | 1 | Initiator ready for data |
| bus_be | output | DATA_W/8 | Byte enables on the bus |
| tgt_ready | input | 1 | Target presents data this cycle |
| tgt_data | input | DATA_W | Read data from the target |
| tgt_retry | input | 1 | Target retry, no data |
| tgt_disconnect | input | 1 | Target ends the transaction after this cycle |
| tgt_abort | input | 1 | Target abort |
| fifo_valid | output | 1 | Received word valid |
| fifo_data | output | DATA_W | Received word |
| fifo_ready | input | 1 | Downstream FIFO can accept |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| end_code | output | 3 | End cause: 0 complete, 1 master abort, 2 target abort, 3 stopped, 4 bus reset, 5 alignment error |

## Verification
The bench sweeps every 4-byte start offset in a 64-byte window against several counts, including the largest count, under eight target and FIFO behaviours. This catches a sequencer that uses the wrong bit for single-transfer mode, that starts bursts from unaligned addresses, or that runs the full count when bit 2 is set. Retry and disconnect patterns test the resume address: a design that restarts from the start address, or counts a retried cycle as data, gets the wrong address or the wrong data. The timeout is tested both with five silent cycles and with a reply in the fifth cycle, which exposes an off-by-one limit. Stop, abort and bus reset are placed in cycles where the target also presents data, so an error in termination priority or in data gating shows up as a lost or extra word.

// File: rtl/mrd_pkg.sv
// Shared types for the burst master read sequencer.
// Assumes: end code values are part of the external contract.
package mrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } seq_state_t;

    typedef enum logic [2:0] {
        END_OK     = 3'd0,
        END_MABORT = 3'd1,
        END_TABORT = 3'd2,
        END_STOP   = 3'd3,
        END_BUSRST = 3'd4,
        END_ALIGN  = 3'd5
    } end_code_t;

endpackage

// File: rtl/mrd_setup_check.sv
// Classifies a start request from the low address bits and the count.
// Assumes: QW_BYTES and ALIGN_BYTES are powers of two, ALIGN_BYTES > QW_BYTES.
module mrd_setup_check #(
    parameter int CNT_W       = 18,
    parameter int QW_BYTES    = 8,
    parameter int ALIGN_BYTES = 64,
    localparam int ALIGN_LSB  = $clog2(ALIGN_BYTES),
    localparam int QW_LSB     = $clog2(QW_BYTES)
) (
    input  logic [ALIGN_LSB-1:0] addr_low,
    input  logic [CNT_W-1:0]     count,
    output logic                 is_zero,
    output logic                 is_single,
    output logic                 is_misaligned,
    output logic [CNT_W-1:0]     eff_count
);

    // Decode: half-word-offset start forces one transfer, otherwise burst must be aligned
    always_comb begin
        is_zero       = (count == '0);
        is_single     = addr_low[QW_LSB-1];
        is_misaligned = !is_single && (addr_low[ALIGN_LSB-1:QW_LSB] != '0);
        eff_count     = is_single ? CNT_W'(1) : count;
    end

endmodule

// File: rtl/mrd_tracker.sv
// Holds the next quad-word address and the count of words still owed.
// Assumes: advance is only raised while remaining is non-zero.
module mrd_tracker #(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 18,
    parameter int QW_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_word,
    output logic              multi
);

    logic [CNT_W-1:0] remaining;

    // Load on start, step address and count on each received word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remaining <= '0;
        end else if (load) begin
            cur_addr  <= load_addr;
            remaining <= load_count;
        end else if (advance) begin
            cur_addr  <= cur_addr + ADDR_W'(QW_BYTES);
            remaining <= remaining - CNT_W'(1);
        end
    end

    // Flags for the controller and the address phase
    always_comb begin
        last_word = (remaining == CNT_W'(1));
        multi     = (remaining > CNT_W'(1));
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (remaining != '0)); // R6

endmodule

// File: rtl/mrd_timeout.sv
// Counts silent data-phase cycles after an address phase and flags a master abort.
// Assumes: arm is raised in the address phase, active throughout the data phase.
module mrd_timeout #(
    parameter int LIMIT = 5,
    localparam int TW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic active,
    input  logic resp,
    output logic expire
);

    logic [TW-1:0] cnt;
    logic          seen;

    // Track silent cycles until the first target response of the transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (arm) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (active) begin
            if (resp)
                seen <= 1'b1;
            else if (!seen)
                cnt <= cnt + TW'(1);
        end
    end

    // Expire in the last allowed silent cycle
    assign expire = active && !resp && !seen && (cnt == TW'(LIMIT - 1));

    AST_TO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < TW'(LIMIT))); // R9

endmodule

// File: rtl/mrd_ctrl.sv
// Phase controller: accepts starts, sequences address and data phases,
// resumes after retry or disconnect, and ranks the end causes.
// Assumes: inputs are synchronous to clk; end_code is meaningful with done.
module mrd_ctrl
    import mrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_zero,
    input  logic       is_misaligned,
    input  logic       bus_reset,
    input  logic       stop_req,
    input  logic       tgt_ready,
    input  logic       tgt_retry,
    input  logic       tgt_disconnect,
    input  logic       tgt_abort,
    input  logic       fifo_ready,
    input  logic       last_word,
    input  logic       to_expire,
    output logic       load,
    output logic       xfer,
    output logic       addr_phase,
    output logic       data_phase,
    output logic       busy,
    output logic       done,
    output logic [2:0] end_code
);

    seq_state_t state, nxt;
    logic       fin;
    end_code_t  fin_code, code_q;

    // Phase decode
    always_comb begin
        addr_phase = (state == ST_ADDR);
        data_phase = (state == ST_DATA);
        busy       = (state != ST_IDLE);
        xfer       = data_phase && fifo_ready && tgt_ready &&
                     !tgt_retry && !tgt_abort && !bus_reset;
    end

    // Next phase and end cause, highest-priority cause first
    always_comb begin
        nxt      = state;
        fin      = 1'b0;
        fin_code = END_OK;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start && !bus_reset) begin
                    if (is_zero) begin
                        fin = 1'b1;
                    end else if (is_misaligned) begin
                        fin      = 1'b1;
                        fin_code = END_ALIGN;
                    end else begin
                        load = 1'b1;
                        nxt  = ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                if (bus_reset) begin
                    fin      = 1'b1;
                    fin_code = END_BUSRST;
                end else if (stop_req) begin
                    fin      = 1'b1;
                    fin_code = END_STOP;
                end else begin
                    nxt = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bus_reset) begin
                    fin      = 1'b1;
                    fin_code = END_BUSRST;
                end else if (tgt_abort) begin
                    fin      = 1'b1;
                    fin_code = END_TABORT;
                end else if (to_expire) begin
                    fin      = 1'b1;
                    fin_code = END_MABORT;
                end else if (xfer && last_word) begin
                    fin = 1'b1;
                end else if (stop_req) begin
                    fin      = 1'b1;
                    fin_code = END_STOP;
                end else if (tgt_retry || tgt_disconnect) begin
                    nxt = ST_ADDR;
                end
            end
            default: nxt = ST_IDLE;
        endcase
        if (fin)
            nxt = ST_IDLE;
    end

    // Phase register and registered end report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done   <= 1'b0;
            code_q <= END_OK;
        end else begin
            state <= nxt;
            done  <= fin;
            if (fin)
                code_q <= fin_code;
        end
    end

    assign end_code = code_q;

    AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |=> !addr_phase); // R5
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_ALIGN_NO_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !bus_reset && !is_zero && is_misaligned)
        |=> (!busy && done && end_code == END_ALIGN)); // R3
    AST_TABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && tgt_abort && !bus_reset)
        |=> (done && end_code == END_TABORT)); // R8

endmodule

// File: rtl/mrd_burst_seq.sv
// Burst master read sequencer top: wires the start classifier, the address
// and count tracker, the response timeout and the phase controller, and
// passes received quad words straight to the downstream FIFO.
// Assumes: one operation at a time; starts while busy are ignored.
module mrd_burst_seq #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 18,
    parameter int DATA_W      = 64,
    parameter int ALIGN_BYTES = 64,
    parameter int TIMEOUT     = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     start_addr,
    input  logic [CNT_W-1:0]      start_count,
    input  logic                  stop_req,
    input  logic                  bus_reset,
    input  logic [DATA_W/8-1:0]   rd_be,
    output logic                  bus_addr_valid,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic                  bus_burst,
    output logic                  bus_data_phase,
    output logic                  bus_irdy,
    output logic [DATA_W/8-1:0]   bus_be,
    input  logic                  tgt_ready,
    input  logic [DATA_W-1:0]     tgt_data,
    input  logic                  tgt_retry,
    input  logic                  tgt_disconnect,
    input  logic                  tgt_abort,
    output logic                  fifo_valid,
    output logic [DATA_W-1:0]     fifo_data,
    input  logic                  fifo_ready,
    output logic                  busy,
    output logic                  done,
    output logic [2:0]            end_code
);

    localparam int QW_BYTES  = DATA_W / 8;
    localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

    logic             is_zero, is_single, is_misaligned;
    logic [CNT_W-1:0] eff_count;
    logic             load, xfer, addr_phase, data_phase;
    logic             last_word, multi, to_expire, tgt_resp;

    mrd_setup_check #(
        .CNT_W(CNT_W), .QW_BYTES(QW_BYTES), .ALIGN_BYTES(ALIGN_BYTES)
    ) u_check (
        .addr_low(start_addr[ALIGN_LSB-1:0]),
        .count(start_count),
        .is_zero(is_zero),
        .is_single(is_single),
        .is_misaligned(is_misaligned),
        .eff_count(eff_count)
    );

    mrd_tracker #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .QW_BYTES(QW_BYTES)
    ) u_track (
        .clk(clk),
        .rst_n(rst_n),
        .load(load),
        .load_addr(start_addr),
        .load_count(eff_count),
        .advance(xfer),
        .cur_addr(bus_addr),
        .last_word(last_word),
        .multi(multi)
    );

    // Any target reaction counts as a response for the timeout
    assign tgt_resp = tgt_ready || tgt_retry || tgt_disconnect || tgt_abort;

    mrd_timeout #(.LIMIT(TIMEOUT)) u_to (
        .clk(clk),
        .rst_n(rst_n),
        .arm(addr_phase),
        .active(data_phase),
        .resp(tgt_resp),
        .expire(to_expire)
    );

    mrd_ctrl u_ctrl (
        .clk(clk),
        .rst_n(rst_n),
        .start(start),
        .is_zero(is_zero),
        .is_misaligned(is_misaligned),
        .bus_reset(bus_reset),
        .stop_req(stop_req),
        .tgt_ready(tgt_ready),
        .tgt_retry(tgt_retry),
        .tgt_disconnect(tgt_disconnect),
        .tgt_abort(tgt_abort),
        .fifo_ready(fifo_ready),
        .last_word(last_word),
        .to_expire(to_expire),
        .load(load),
        .xfer(xfer),
        .addr_phase(addr_phase),
        .data_phase(data_phase),
        .busy(busy),
        .done(done),
        .end_code(end_code)
    );

    // Bus-side drive: byte enables only while data moves, irdy from FIFO space
    always_comb begin
        bus_addr_valid = addr_phase;
        bus_burst      = addr_phase && multi;
        bus_data_phase = data_phase;
        bus_irdy       = data_phase && fifo_ready;
        bus_be         = data_phase ? rd_be : '0;
        fifo_valid     = xfer;
        fifo_data      = tgt_data;
    end

    AST_NO_PUSH_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_valid |-> fifo_ready); // R12

endmodule

// File: tb/tb_mrd_burst_seq.sv
// Sweep bench: start offsets x counts x target/FIFO behaviours, expected
// words, addresses and end codes computed arithmetically here.
module tb_mrd_burst_seq;

    localparam logic [31:0] BASE = 32'h0001_2300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [17:0] start_count = '0;
    logic        stop_req = 1'b0;
    logic        bus_reset = 1'b0;
    logic [7:0]  rd_be = '0;
    logic        bus_addr_valid;
    logic [31:0] bus_addr;
    logic        bus_burst;
    logic        bus_data_phase;
    logic        bus_irdy;
    logic [7:0]  bus_be;
    logic        tgt_ready = 1'b0;
    logic [63:0] tgt_data = '0;
    logic        tgt_retry = 1'b0;
    logic        tgt_disconnect = 1'b0;
    logic        tgt_abort = 1'b0;
    logic        fifo_valid;
    logic [63:0] fifo_data;
    logic        fifo_ready = 1'b1;
    logic        busy;
    logic        done;
    logic [2:0]  end_code;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    mrd_burst_seq dut (.*);

    function automatic logic [63:0] pat(input logic [31:0] a);
        return {~a, a ^ 32'h5A5A_0F0F};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
            finish_run();
        end
    end

    task automatic clear_inputs();
        tgt_ready = 0; tgt_retry = 0; tgt_disconnect = 0; tgt_abort = 0;
        stop_req = 0; bus_reset = 0; tgt_data = '0;
    endtask

    // One operation under a target/FIFO behaviour 'mode'
    task automatic do_op(input logic [31:0] a, input logic [17:0] n, input int mode);
        int eff, exp_words, got, beat, dcyc, txn, sil, n_addr, cyc;
        logic [2:0] exp_code;
        logic [31:0] taddr;
        bit ex;
        string tag;
        got = 0; beat = 0; dcyc = 0; txn = 0; sil = 0; n_addr = 0; cyc = 0; taddr = '0;
        if (n == 0)              eff = 0;
        else if (a[2])           eff = 1;
        else if (a[5:3] != 3'd0) eff = -1;
        else                     eff = int'(n);
        exp_words = (eff < 0) ? 0 : eff;
        exp_code  = 3'd0;
        tag = (n != 0 && a[2]) ? "R4" : "R6";
        if (n == 0) tag = "R2";
        else if (eff < 0) begin exp_code = 3'd5; tag = "R3"; end
        else begin
            case (mode)
                3: if (eff >= 3) begin exp_code = 3'd2; exp_words = 2; tag = "R8"; end
                4: begin exp_code = 3'd1; exp_words = 0; tag = "R9"; end
                6: if (eff >= 3) begin exp_code = 3'd3; exp_words = 2; tag = "R10"; end
                7: if (eff >= 2) begin exp_code = 3'd4; exp_words = 1; tag = "R11"; end
                default: ;
            endcase
        end

        @(negedge clk);
        start = 1; start_addr = a; start_count = n;
        @(negedge clk);
        start = 0;
        while (!done && cyc < 400) begin
            clear_inputs();
            fifo_ready = (mode == 2) ? (cyc % 3 != 0) : 1'b1;
            rd_be = 8'(cyc * 37 + 1);
            #1;
            if (bus_addr_valid) begin
                n_addr++; txn++; dcyc = 0; beat = 0; taddr = bus_addr;
                chk("R7 address phase address", bus_addr, a + 32'(8 * got));
                chk("R5 burst flag", bus_burst, (eff - got) > 1);
            end
            if (bus_data_phase) begin
                case (mode)
                    0: tgt_ready = 1;
                    1: if (txn % 2 == 1 && dcyc == 0) tgt_retry = 1;
                       else begin tgt_ready = 1; if (beat == 1) tgt_disconnect = 1; end
                    2: tgt_ready = (dcyc >= 1);
                    3: begin tgt_ready = 1; if (got == 2) tgt_abort = 1; end
                    5: tgt_ready = (dcyc >= 4);
                    6: begin tgt_ready = 1; if (got == 1) stop_req = 1; end
                    7: begin tgt_ready = 1; if (got == 1) bus_reset = 1; end
                    default: ;
                endcase
                tgt_data = pat(taddr + 32'(8 * beat));
                #1;
                ex = fifo_ready && tgt_ready && !tgt_retry && !tgt_abort && !bus_reset;
                chk("R12 irdy follows fifo_ready", bus_irdy, fifo_ready);
                chk("R12 word taken", fifo_valid, ex);
                chk("R13 byte enables in data phase", bus_be, rd_be);
                if (ex) begin
                    chk("R6 received word", fifo_data, pat(a + 32'(8 * got)));
                    got++; beat++;
                end
                if (!tgt_ready && !tgt_retry && !tgt_abort && !tgt_disconnect) sil++;
                dcyc++;
            end else begin
                chk("R13 byte enables quiet", bus_be, 8'h00);
                chk("R12 no push outside data", fifo_valid, 1'b0);
            end
            @(negedge clk);
            cyc++;
        end
        clear_inputs();
        fifo_ready = 1;
        chk({tag, " operation ended"}, cyc < 400, 1'b1);
        chk({tag, " end code"}, end_code, exp_code);
        chk({tag, " words received"}, got, exp_words);
        if (eff <= 0) chk({tag, " no address phase"}, n_addr, 0);
        if (mode == 4 && eff > 0) chk("R9 silent cycles before abort", sil, 5);
    endtask

    function automatic logic [17:0] nval(input int k);
        case (k)
            0: return 18'd0;
            1: return 18'd1;
            2: return 18'd2;
            3: return 18'd3;
            4: return 18'd5;
            default: return 18'h3FFFF;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 1'b0);
        chk("R1 done in reset", done, 1'b0);
        chk("R1 addr strobe in reset", bus_addr_valid, 1'b0);
        chk("R1 data phase in reset", bus_data_phase, 1'b0);
        chk("R1 irdy in reset", bus_irdy, 1'b0);
        chk("R1 fifo_valid in reset", fifo_valid, 1'b0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", {busy, done, bus_addr_valid, fifo_valid}, 4'b0);

        for (int mode = 0; mode < 8; mode++) begin
            for (int off = 0; off < 16; off++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [31:0] a;
                    a = BASE + 32'(off * 4);
                    if (!(k == 5 && a[5:0] == 6'd0))
                        do_op(a, nval(k), mode);
                end
            end
        end
        do_op(BASE + 32'd192, 18'd40, 1);
        do_op(BASE, 18'd40, 2);
        do_op(BASE + 32'd64, 18'd17, 5);
        finish_run();
    end

endmodule